// File: doc/BRIEF.md
# Masked CAM Command Datapath

This block is the storage and data-movement side of a content-addressable memory. It holds a parameterized array of 64-bit entries, each with a validity flag, along with a 64-bit comparand register, an address register and a small bank of mask registers. A 12-bit command word, a write strobe and a half-select input pick one of several data moves. The moves run between a 32-bit bus, the comparand and the memory array. Every move into the array or into the comparand is merged bit by bit under one selectable mask register.

The block does not choose locations itself. A companion priority resolver supplies the index of the next free entry and the index of the highest-priority matching entry, along with flags that say whether each index is usable. The block exports the validity vector and the comparand so that the resolver and the compare logic can use them. Bus data arrives on `bus_in`. Read data leaves on `bus_out`, qualified by `bus_oe`, so that a pad or bus wrapper can build the shared bus from these signals.

Top module: `cam_cmd_datapath`

## Requirements
- R1: The block decodes a command only while `cmd_valid` is high. The mask selector is bits 8:6 and the operation code is bits 5:0. Bits 11:9 are don't-care. Any operation code other than 000001, 001100, 001101 and 001110 has no effect on memory, validity, comparand, bus or error outputs.
- R2: Mask selector 0 applies no mask. For a nonzero selector, only bit positions where that mask register holds 0 take new data. All mask registers reset to zero, so any selector is unmasked until its mask register is loaded.
- R3: Opcode 000001 with `wr_en`=1 and `nf_avail`=1 writes `bus_in` into entry `nf_idx`. It writes bits 31:0 when `half_hi`=0 and bits 63:32 when `half_hi`=1, merged under the same half of the selected mask. The other half of the entry is unchanged.
- R4: Opcode 000001 with `wr_en`=0 and `hpm_hit`=1 drives the selected half of entry `hpm_idx` on `bus_out`, with `bus_oe` high, in the cycle after the command. With `hpm_hit`=0, `bus_oe` stays low.
- R5: Opcode 001100 with `wr_en`=0 loads the entry addressed by the address register into the comparand, all 64 bits merged under the mask. It leaves every validity bit unchanged.
- R6: Opcode 001100 with `wr_en`=1 writes the comparand into the entry addressed by the address register, all 64 bits merged under the mask.
- R7: With `wr_en`=1, opcode 001101 writes the comparand into entry `nf_idx` when `nf_avail`=1, and opcode 001110 writes it into entry `hpm_idx` when `hpm_hit`=1. Otherwise no entry changes.
- R8: Every write into an entry sets its validity bit to the inverse of `vld_n` (0 means valid, 1 means empty). Reset clears all validity bits and the comparand.
- R9: A comparand move (opcode 001100, or 001101/001110 with `wr_en`=1) issued with `half_hi`=1 is dropped. `err` is high for exactly the following cycle.
- R10: `bus_oe` is high only in the cycle after a hitting read (R4). It is low after writes, moves and idle cycles.
- R11: `ar_we` loads `ar_din` into the address register, and `mask_we` loads `mask_din` into mask register `mask_addr`. Each load takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 12 | Command word: mask selector 8:6, opcode 5:0 |
| wr_en | input | 1 | Write strobe; flips the direction of opcodes 000001 and 001100 |
| half_hi | input | 1 | Selects the upper half of an entry for bus accesses |
| vld_n | input | 1 | Validity value for written entries, active low |
| bus_in | input | 32 | Write data from the bus |
| bus_out | output | 32 | Read data to the bus |
| bus_oe | output | 1 | bus_out is driven this cycle |
| nf_idx | input | 4 | Next free entry index from the resolver |
| nf_avail | input | 1 | A free entry exists |
| hpm_idx | input | 4 | Highest-priority matching entry index |
| hpm_hit | input | 1 | The previous comparison matched |
| ar_we | input | 1 | Address register load |
| ar_din | input | 4 | Address register load value |
| mask_we | input | 1 | Mask register load |
| mask_addr | input | 3 | Mask register to load |
| mask_din | input | 64 | Mask register load value |
| cmp_q | output | 64 | Comparand contents |
| entry_valid | output | 16 | Validity bit of every entry |
| err | output | 1 | One-cycle pulse on a dropped half-select violation |

## Verification
The bench targets half-granular writes: a design that wrote the whole word, or used the wrong half of the mask, corrupts the untouched half, and the final read-back exposes it. It checks that the opcode shared by reads and writes reverses its direction with the strobe. A swapped decode would load the comparand instead of storing it, or the reverse. It drives comparand moves with the upper half selected: an ungated design writes anyway, and a sticky error flag stays high on the idle cycle that follows. It also issues misses with the resolver flags low, which catches a design that enables the bus or writes a stale index.

// File: rtl/cam_cmd_pkg.sv
package cam_cmd_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_WR_NF,
      OP_RD_HPM,
      OP_MEM2CR,
      OP_CR2AR,
      OP_CR2NF,
      OP_CR2HPM
   } cam_op_e;

   localparam logic [5:0] OPC_BUS_NF   = 6'b000001;
   localparam logic [5:0] OPC_AR_MOVE  = 6'b001100;
   localparam logic [5:0] OPC_CR_NF    = 6'b001101;
   localparam logic [5:0] OPC_CR_HPM   = 6'b001110;
   localparam int         OPC_W        = 6;

endpackage

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
   import cam_cmd_pkg::*;
#(
   parameter int CMD_W  = 12,
   parameter int MSEL_W = 3
) (
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd,
   input  logic              wr_en,
   input  logic              half_hi,
   output cam_op_e           op,
   output logic [MSEL_W-1:0] msel,
   output logic              half_err
);

   if (CMD_W < OPC_W + MSEL_W) begin : g_bad_cmd_w
      $error("cam_cmd_decode: CMD_W too narrow for opcode and mask selector");
   end

   logic [OPC_W-1:0] opc;
   cam_op_e          raw_op;
   logic             cr_move;

   assign opc  = cmd[OPC_W-1:0];
   assign msel = cmd[OPC_W +: MSEL_W];

   always_comb begin
      raw_op = OP_NONE;
      if (cmd_valid) begin
         case (opc)
            OPC_BUS_NF:  raw_op = wr_en ? OP_WR_NF : OP_RD_HPM;
            OPC_AR_MOVE: raw_op = wr_en ? OP_CR2AR : OP_MEM2CR;
            OPC_CR_NF:   raw_op = wr_en ? OP_CR2NF : OP_NONE;
            OPC_CR_HPM:  raw_op = wr_en ? OP_CR2HPM : OP_NONE;
            default:     raw_op = OP_NONE;
         endcase
      end
   end

   assign cr_move  = (raw_op == OP_MEM2CR) || (raw_op == OP_CR2AR) ||
                     (raw_op == OP_CR2NF)  || (raw_op == OP_CR2HPM);
   assign half_err = cr_move && half_hi;
   assign op       = half_err ? OP_NONE : raw_op;

endmodule

// File: rtl/cam_mask_bank.sv
module cam_mask_bank #(
   parameter int W            = 64,
   parameter int N            = 8,
   parameter bit ZERO_IS_NONE = 1'b1,
   localparam int SW          = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [SW-1:0] sel,
   output logic [W-1:0]  keep
);

   if (N < 2) begin : g_bad_n
      $error("cam_mask_bank: at least two mask registers required");
   end

   logic [W-1:0] regs_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[waddr] <= wdata;
      end
   end

   if (ZERO_IS_NONE) begin : g_zero_none
      assign keep = (sel == '0) ? '0 : regs_q[sel];
   end else begin : g_all_regs
      assign keep = regs_q[sel];
   end

endmodule

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
   parameter int W     = 64,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    widx,
   input  logic [W-1:0]     wdata,
   input  logic [W-1:0]     wkeep,
   input  logic             wvld,
   input  logic [AW-1:0]    ridx,
   output logic [W-1:0]     rdata,
   output logic [DEPTH-1:0] vld_vec
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("cam_entry_store: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0] mem_q [DEPTH];
   logic         vld_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
            vld_q[i] <= 1'b0;
         end
      end else if (we) begin
         mem_q[widx] <= (mem_q[widx] & wkeep) | (wdata & ~wkeep);
         vld_q[widx] <= wvld;
      end
   end

   assign rdata = mem_q[ridx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign vld_vec[g] = vld_q[g];
   end

endmodule

// File: rtl/cam_cmd_datapath.sv
module cam_cmd_datapath
   import cam_cmd_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int BUS_W   = 32,
   parameter int NMASK   = 8,
   parameter int CMD_W   = 12,
   localparam int ENT_W  = 2 * BUS_W,
   localparam int AW     = $clog2(DEPTH),
   localparam int MSW    = $clog2(NMASK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd,
   input  logic             wr_en,
   input  logic             half_hi,
   input  logic             vld_n,
   input  logic [BUS_W-1:0] bus_in,
   output logic [BUS_W-1:0] bus_out,
   output logic             bus_oe,
   input  logic [AW-1:0]    nf_idx,
   input  logic             nf_avail,
   input  logic [AW-1:0]    hpm_idx,
   input  logic             hpm_hit,
   input  logic             ar_we,
   input  logic [AW-1:0]    ar_din,
   input  logic             mask_we,
   input  logic [MSW-1:0]   mask_addr,
   input  logic [ENT_W-1:0] mask_din,
   output logic [ENT_W-1:0] cmp_q,
   output logic [DEPTH-1:0] entry_valid,
   output logic             err
);

   if (NMASK != 8) begin : g_bad_nmask
      $error("cam_cmd_datapath: mask selector field is three bits wide");
   end

   cam_op_e          op;
   logic [MSW-1:0]   msel;
   logic             half_err;
   logic [ENT_W-1:0] keep;
   logic [AW-1:0]    ar_q;
   logic             st_we;
   logic [AW-1:0]    st_widx;
   logic [ENT_W-1:0] st_wdata;
   logic [ENT_W-1:0] st_wkeep;
   logic [AW-1:0]    st_ridx;
   logic [ENT_W-1:0] st_rdata;
   logic [ENT_W-1:0] bus_wide;
   logic [ENT_W-1:0] bus_keep;

   cam_cmd_decode #(.CMD_W(CMD_W), .MSEL_W(MSW)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd       (cmd),
      .wr_en     (wr_en),
      .half_hi   (half_hi),
      .op        (op),
      .msel      (msel),
      .half_err  (half_err)
   );

   cam_mask_bank #(.W(ENT_W), .N(NMASK), .ZERO_IS_NONE(1'b1)) u_masks (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .waddr (mask_addr),
      .wdata (mask_din),
      .sel   (msel),
      .keep  (keep)
   );

   cam_entry_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (st_we),
      .widx    (st_widx),
      .wdata   (st_wdata),
      .wkeep   (st_wkeep),
      .wvld    (~vld_n),
      .ridx    (st_ridx),
      .rdata   (st_rdata),
      .vld_vec (entry_valid)
   );

   // Bus data is placed in one half; the other half is protected entirely.
   assign bus_wide = half_hi ? {bus_in, {BUS_W{1'b0}}} : {{BUS_W{1'b0}}, bus_in};
   assign bus_keep = half_hi ? {keep[ENT_W-1:BUS_W], {BUS_W{1'b1}}}
                             : {{BUS_W{1'b1}}, keep[BUS_W-1:0]};
   assign st_ridx  = (op == OP_RD_HPM) ? hpm_idx : ar_q;

   always_comb begin
      st_we    = 1'b0;
      st_widx  = nf_idx;
      st_wdata = cmp_q;
      st_wkeep = keep;
      case (op)
         OP_WR_NF: begin
            st_we    = nf_avail;
            st_wdata = bus_wide;
            st_wkeep = bus_keep;
         end
         OP_CR2AR: begin
            st_we   = 1'b1;
            st_widx = ar_q;
         end
         OP_CR2NF: st_we = nf_avail;
         OP_CR2HPM: begin
            st_we   = hpm_hit;
            st_widx = hpm_idx;
         end
         default: st_we = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_q    <= '0;
         cmp_q   <= '0;
         bus_out <= '0;
         bus_oe  <= 1'b0;
         err     <= 1'b0;
      end else begin
         err    <= half_err;
         bus_oe <= (op == OP_RD_HPM) && hpm_hit;
         if (ar_we) ar_q <= ar_din;
         if (op == OP_MEM2CR) cmp_q <= (cmp_q & keep) | (st_rdata & ~keep);
         if ((op == OP_RD_HPM) && hpm_hit)
            bus_out <= half_hi ? st_rdata[ENT_W-1:BUS_W] : st_rdata[BUS_W-1:0];
      end
   end

endmodule

// File: rtl/cam_cmd_datapath_chk.sv
module cam_cmd_datapath_chk #(
   parameter int DEPTH = 16,
   parameter int BUS_W = 32,
   parameter int NMASK = 8,
   parameter int CMD_W = 12,
   localparam int ENT_W = 2 * BUS_W,
   localparam int AW    = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [CMD_W-1:0] cmd,
   input logic             wr_en,
   input logic             half_hi,
   input logic             vld_n,
   input logic             bus_oe,
   input logic [AW-1:0]    nf_idx,
   input logic             nf_avail,
   input logic             hpm_hit,
   input logic [ENT_W-1:0] cmp_q,
   input logic [DEPTH-1:0] entry_valid,
   input logic             err
);

   logic is_bus_op, is_ar_op, is_cr_wr;
   assign is_bus_op = cmd_valid && (cmd[5:0] == 6'b000001);
   assign is_ar_op  = cmd_valid && (cmd[5:0] == 6'b001100);
   assign is_cr_wr  = cmd_valid && wr_en &&
                      ((cmd[5:0] == 6'b001101) || (cmd[5:0] == 6'b001110));

   assert_half_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_ar_op || is_cr_wr) && half_hi) |=> err);

   assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($stable(entry_valid) && $stable(cmp_q)));

   assert_oe_only_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> $past(is_bus_op && !wr_en && hpm_hit));

   assert_miss_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_bus_op && !wr_en && !hpm_hit) |=> !bus_oe);

   assert_m2c_keeps_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ar_op && !wr_en) |=> $stable(entry_valid));

   assert_valid_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_bus_op && wr_en && nf_avail) |=>
         (entry_valid[$past(nf_idx)] == !$past(vld_n)));

endmodule

bind cam_cmd_datapath cam_cmd_datapath_chk #(
   .DEPTH (DEPTH),
   .BUS_W (BUS_W),
   .NMASK (NMASK),
   .CMD_W (CMD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd         (cmd),
   .wr_en       (wr_en),
   .half_hi     (half_hi),
   .vld_n       (vld_n),
   .bus_oe      (bus_oe),
   .nf_idx      (nf_idx),
   .nf_avail    (nf_avail),
   .hpm_hit     (hpm_hit),
   .cmp_q       (cmp_q),
   .entry_valid (entry_valid),
   .err         (err)
);

// File: tb/cam_cmd_datapath_tb.sv
module cam_cmd_datapath_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [11:0] cmd = '0;
   logic        wr_en = 1'b0, half_hi = 1'b0, vld_n = 1'b0;
   logic [31:0] bus_in = '0;
   logic [31:0] bus_out;
   logic        bus_oe;
   logic [3:0]  nf_idx = '0, hpm_idx = '0, ar_din = '0;
   logic        nf_avail = 1'b0, hpm_hit = 1'b0, ar_we = 1'b0, mask_we = 1'b0;
   logic [2:0]  mask_addr = '0;
   logic [63:0] mask_din = '0;
   logic [63:0] cmp_q;
   logic [15:0] entry_valid;
   logic        err;

   int n_chk = 0, n_err = 0;

   logic [63:0] m_mem [16];
   logic [15:0] m_vld;
   logic [63:0] m_cmp;
   logic [63:0] m_mask [8];
   logic [3:0]  m_ar;

   always #4 clk = ~clk;

   cam_cmd_datapath u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .wr_en(wr_en),
      .half_hi(half_hi), .vld_n(vld_n), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .nf_idx(nf_idx), .nf_avail(nf_avail), .hpm_idx(hpm_idx),
      .hpm_hit(hpm_hit), .ar_we(ar_we), .ar_din(ar_din), .mask_we(mask_we),
      .mask_addr(mask_addr), .mask_din(mask_din), .cmp_q(cmp_q),
      .entry_valid(entry_valid), .err(err)
   );

   function automatic logic [63:0] mrg(input logic [63:0] old, nw, keep);
      return (old & keep) | (nw & ~keep);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_chk();
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(err == 1'b0, "R9 err lasts one cycle", {63'b0, err}, 64'd0);
      chk(bus_oe == 1'b0, "R10 bus_oe idle", {63'b0, bus_oe}, 64'd0);
   endtask

   task automatic load_mask(input logic [2:0] a, input logic [63:0] d);
      mask_we = 1'b1; mask_addr = a; mask_din = d;
      @(negedge clk);
      mask_we = 1'b0;
      m_mask[a] = d;
   endtask

   task automatic load_ar(input logic [3:0] a);
      ar_we = 1'b1; ar_din = a;
      @(negedge clk);
      ar_we = 1'b0;
      m_ar = a;
   endtask

   // Drives one command at a falling edge; checks at the next falling edge.
   task automatic do_cmd(input logic [11:0] c, input logic wr, hh, vn,
                         input logic [31:0] b, input logic [3:0] nf,
                         input logic na, input logic [3:0] hp, input logic hit);
      logic [5:0]  opc;
      logic [63:0] msk;
      logic        bad, e_oe;
      logic [31:0] e_bus;
      opc = c[5:0];
      msk = (c[8:6] == 3'd0) ? 64'd0 : m_mask[c[8:6]];
      bad = hh && ((opc == 6'b001100) ||
                   (wr && ((opc == 6'b001101) || (opc == 6'b001110))));
      e_oe = 1'b0; e_bus = '0;
      if (!bad) begin
         if (opc == 6'b000001 && wr && na) begin
            if (hh) m_mem[nf][63:32] = mrg({32'b0, m_mem[nf][63:32]}, {32'b0, b}, {32'b0, msk[63:32]}) ;
            else    m_mem[nf][31:0]  = mrg({32'b0, m_mem[nf][31:0]},  {32'b0, b}, {32'b0, msk[31:0]});
            m_vld[nf] = !vn;
         end
         if (opc == 6'b000001 && !wr && hit) begin
            e_oe  = 1'b1;
            e_bus = hh ? m_mem[hp][63:32] : m_mem[hp][31:0];
         end
         if (opc == 6'b001100 && !wr) m_cmp = mrg(m_cmp, m_mem[m_ar], msk);
         if (opc == 6'b001100 && wr) begin
            m_mem[m_ar] = mrg(m_mem[m_ar], m_cmp, msk); m_vld[m_ar] = !vn;
         end
         if (opc == 6'b001101 && wr && na) begin
            m_mem[nf] = mrg(m_mem[nf], m_cmp, msk); m_vld[nf] = !vn;
         end
         if (opc == 6'b001110 && wr && hit) begin
            m_mem[hp] = mrg(m_mem[hp], m_cmp, msk); m_vld[hp] = !vn;
         end
      end
      cmd = c; wr_en = wr; half_hi = hh; vld_n = vn; bus_in = b;
      nf_idx = nf; nf_avail = na; hpm_idx = hp; hpm_hit = hit; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(err == bad, "R9 half-select error flag", {63'b0, err}, {63'b0, bad});
      chk(bus_oe == e_oe, "R10 bus_oe", {63'b0, bus_oe}, {63'b0, e_oe});
      if (e_oe) chk(bus_out == e_bus, "R4 R3 R6 R7 read data", {32'b0, bus_out}, {32'b0, e_bus});
      chk(cmp_q == m_cmp, "R5 comparand", cmp_q, m_cmp);
      chk(entry_valid == m_vld, "R8 validity", {48'b0, entry_valid}, {48'b0, m_vld});
   endtask

   task automatic dump_all();
      for (int i = 0; i < 16; i++)
         for (int h = 0; h < 2; h++)
            do_cmd(12'h001, 1'b0, h[0], 1'b1, '0, '0, 1'b0, i[3:0], 1'b1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      for (int i = 0; i < 8; i++) m_mask[i] = '0;
      m_vld = '0; m_cmp = '0; m_ar = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk(err == 1'b0, "R9 reset err", {63'b0, err}, 64'd0);
      chk(bus_oe == 1'b0, "R10 reset bus_oe", {63'b0, bus_oe}, 64'd0);
      chk(cmp_q == 64'd0, "R8 reset comparand", cmp_q, 64'd0);
      chk(entry_valid == 16'd0, "R8 reset validity", {48'b0, entry_valid}, 64'd0);

      // R2: masks reset to zero, so selector 5 writes every bit
      do_cmd({3'b101, 3'd5, 6'b000001}, 1'b1, 1'b0, 1'b0, 32'hA5A5_1234, 4'd3, 1'b1, '0, 1'b0);
      do_cmd({3'b000, 3'd5, 6'b000001}, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 4'd3, 1'b1, '0, 1'b0);
      do_cmd(12'h001, 1'b0, 1'b0, 1'b1, '0, '0, 1'b0, 4'd3, 1'b1);
      chk(bus_out == 32'hA5A5_1234, "R2 reset mask is transparent", {32'b0, bus_out}, 64'hA5A5_1234);

      // R11 + R5: address register drives the memory-to-comparand move
      load_ar(4'd3);
      do_cmd({3'b0, 3'd0, 6'b001100}, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
      chk(cmp_q == 64'hDEAD_BEEF_A5A5_1234, "R11 address register load", cmp_q, 64'hDEAD_BEEF_A5A5_1234);

      // R2 masked move, R7 comparand to next free, stored empty
      load_mask(3'd2, 64'hFFFF_0000_0000_FFFF);
      do_cmd({3'b0, 3'd2, 6'b001101}, 1'b1, 1'b0, 1'b1, '0, 4'd7, 1'b1, '0, 1'b0);
      do_cmd(12'h001, 1'b0, 1'b0, 1'b1, '0, '0, 1'b0, 4'd7, 1'b1);
      chk(bus_out == 32'hA5A5_0000, "R2 masked bits kept", {32'b0, bus_out}, 64'hA5A5_0000);

      // R9 half-select violation, then idle cycle must drop err
      do_cmd({3'b0, 3'd0, 6'b001100}, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, '0, 1'b0);
      idle_chk();
      do_cmd({3'b0, 3'd0, 6'b001110}, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 4'd9, 1'b1);
      idle_chk();

      // R4 read miss, R7 moves with resolver flags low
      do_cmd(12'h001, 1'b0, 1'b1, 1'b1, '0, '0, 1'b0, 4'd3, 1'b0);
      do_cmd({3'b0, 3'd0, 6'b001110}, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, 4'd9, 1'b0);
      do_cmd({3'b0, 3'd0, 6'b001101}, 1'b1, 1'b0, 1'b0, '0, 4'd9, 1'b0, '0, 1'b0);

      // R1 unknown opcode and upper don't-care bits
      do_cmd({3'b111, 3'd0, 6'b000111}, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 4'd3, 1'b1, 4'd3, 1'b1);
      chk(entry_valid == m_vld, "R1 unknown opcode leaves validity", {48'b0, entry_valid}, {48'b0, m_vld});
      chk(cmp_q == m_cmp, "R1 unknown opcode leaves comparand", cmp_q, m_cmp);

      // Constrained random mix
      for (int it = 0; it < 500; it++) begin
         int          r;
         logic [5:0]  opc;
         r = $urandom_range(0, 15);
         if (r == 0) load_mask($urandom_range(1, 7), {$urandom, $urandom});
         else if (r == 1) load_ar($urandom_range(0, 15));
         else begin
            case ($urandom_range(0, 5))
               0, 1:    opc = 6'b000001;
               2:       opc = 6'b001100;
               3:       opc = 6'b001101;
               4:       opc = 6'b001110;
               default: opc = 6'($urandom);
            endcase
            do_cmd({3'($urandom), 3'($urandom), opc}, 1'($urandom),
                   ($urandom_range(0, 5) == 0) ? 1'($urandom) : (opc == 6'b000001 ? 1'($urandom) : 1'b0),
                   1'($urandom), $urandom, 4'($urandom), ($urandom_range(0, 3) != 0),
                   4'($urandom), ($urandom_range(0, 3) != 0));
         end
      end

      // Full read-back covers R3, R6, R7 contents
      dump_all();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule